// File: doc/BRIEF.md
# Serial Link Request Decoder

This block sits on the physical-layer side of a serial bus and decodes requests that the link layer sends over a single request wire. The wire is sampled once per clock. While the decoder is idle, a sampled 1 starts a frame. The three bits after it give the request type. The type also fixes how many bits follow, so the decoder works out the frame length while the frame is still arriving.

It then collects the fields that belong to that type and checks the final bit. The result is a one-cycle valid pulse. With it come a decoded request kind (immediate, fair, urgent, register read or register write), the priority, the register address and the write data. Frames that are malformed or reserved give a one-cycle error pulse instead, and the decoder goes back to idle.

Arbitration, register access and status return are handled elsewhere. They consume the decoded outputs.

Top module: `lrq_frame_decoder`

## Requirements
- R1: While idle, a sampled 0 on `req_line` keeps the decoder idle with no pulse on either output, and a sampled 1 is taken as a start bit.
- R2: The three type bits follow the start bit, first received as most significant. Codes 000 (immediate), 011 (fair/urgent), 100 (read) and 101 (write) are legal. Codes 001, 010, 110 and 111 make `out_err` pulse on the clock after the third type bit, and the decoder returns to idle.
- R3: Frame lengths, counting start and stop bits, are: 11 bits for types 000 and 011 (2 speed bits, 4 priority bits, stop); 9 bits for type 100 (4 address bits, stop); 17 bits for type 101 (4 address bits, 8 data bits, stop). Every field is collected most significant bit first.
- R4: The two speed bits have no effect on any output.
- R5: For type 011, priority 0000 gives kind fair, priorities 0001 to 1110 give kind urgent with that priority, and 1111 gives an error pulse. Type 000 gives kind immediate for every priority value, 1111 included, and reports that priority.
- R6: A final (stop) bit of 1 gives an error pulse instead of a valid pulse, for every frame type.
- R7: `out_valid` and `out_err` each go high for exactly one cycle, on the clock after the frame's last bit is sampled, and are never high together.
- R8: A start bit sampled on the clock right after a frame's last bit begins a new frame, so back-to-back frames are both decoded.
- R9: Kind is encoded as 0 immediate, 1 fair, 2 urgent, 3 read, 4 write. Read reports the address with priority and data 0. Write reports address and data with priority 0. Immediate, fair and urgent report address and data 0. The fields keep their values until the next valid pulse.
- R10: Reset drives all outputs to 0 and drops any partly received frame. The first frame after reset decodes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_line | input | 1 | Serial request wire, one bit per clock |
| out_valid | output | 1 | One-cycle pulse: a well-formed request was decoded |
| out_err | output | 1 | One-cycle pulse: a frame was rejected |
| out_kind | output | 3 | Decoded request kind |
| out_prio | output | PRIO_W | Priority field |
| out_addr | output | ADDR_W | Register address |
| out_data | output | DATA_W | Register write data |

## Verification
Every result is due exactly one clock after the rising edge that samples the frame's last bit. For legal types that bit is the stop bit. For a reserved type it is the third type bit, since that is where the frame is cut short.

The bench drives each bit at a falling edge. It samples the pulse and the fields at the falling edge that follows the last bit's rising edge. One falling edge later it checks that the pulse has dropped and the fields are held.

The back-to-back case drives the next start bit at that same falling edge. This shows that the one-clock result latency leaves no dead cycle between frames.

// File: rtl/lrq_pkg.sv
package lrq_pkg;
   localparam int TYPE_W = 3;

   localparam logic [TYPE_W-1:0] TY_IMM = 3'b000;
   localparam logic [TYPE_W-1:0] TY_ARB = 3'b011;
   localparam logic [TYPE_W-1:0] TY_RD  = 3'b100;
   localparam logic [TYPE_W-1:0] TY_WR  = 3'b101;

   typedef enum logic [2:0] {
      K_IMM    = 3'd0,
      K_FAIR   = 3'd1,
      K_URGENT = 3'd2,
      K_READ   = 3'd3,
      K_WRITE  = 3'd4
   } lrq_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_TYPE,
      ST_BODY,
      ST_STOP
   } lrq_state_e;
endpackage

// File: rtl/lrq_shift_in.sv
module lrq_shift_in #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("lrq_shift_in: W must be at least 1");
      end
      if (W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (clr) q <= '0;
            else if (en)  q <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (clr) q <= '0;
            else if (en)  q <= {q[W-2:0], din};
         end
      end
   endgenerate
endmodule

// File: rtl/lrq_type_map.sv
module lrq_type_map
   import lrq_pkg::*;
#(
   parameter int CNT_W   = 5,
   parameter int ARB_LEN = 6,
   parameter int RD_LEN  = 4,
   parameter int WR_LEN  = 12
) (
   input  logic [TYPE_W-1:0] typ,
   output logic              legal,
   output logic [CNT_W-1:0]  len_m1
);
   always_comb begin
      legal  = 1'b1;
      len_m1 = '0;
      unique case (typ)
         TY_IMM, TY_ARB: len_m1 = CNT_W'(ARB_LEN - 1);
         TY_RD:          len_m1 = CNT_W'(RD_LEN - 1);
         TY_WR:          len_m1 = CNT_W'(WR_LEN - 1);
         default:        legal  = 1'b0;
      endcase
   end
endmodule

// File: rtl/lrq_classify.sv
module lrq_classify
   import lrq_pkg::*;
#(
   parameter int PRIO_W = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int BODY_W = 12
) (
   input  logic [TYPE_W-1:0] typ,
   input  logic [BODY_W-1:0] body,
   output lrq_kind_e         kind,
   output logic [PRIO_W-1:0] prio,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data,
   output logic              bad_prio
);
   always_comb begin
      kind     = K_IMM;
      prio     = '0;
      addr     = '0;
      data     = '0;
      bad_prio = 1'b0;
      unique case (typ)
         TY_IMM: begin
            prio = body[PRIO_W-1:0];
         end
         TY_ARB: begin
            prio = body[PRIO_W-1:0];
            if (prio == '0)      kind     = K_FAIR;
            else if (&prio)      bad_prio = 1'b1;
            else                 kind     = K_URGENT;
         end
         TY_RD: begin
            kind = K_READ;
            addr = body[ADDR_W-1:0];
         end
         TY_WR: begin
            kind = K_WRITE;
            addr = body[ADDR_W+DATA_W-1:DATA_W];
            data = body[DATA_W-1:0];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/lrq_frame_decoder.sv
module lrq_frame_decoder
   import lrq_pkg::*;
#(
   parameter int SPD_W  = 2,
   parameter int PRIO_W = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_line,
   output logic              out_valid,
   output logic              out_err,
   output logic [2:0]        out_kind,
   output logic [PRIO_W-1:0] out_prio,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);
   localparam int ARB_LEN = SPD_W + PRIO_W;
   localparam int RD_LEN  = ADDR_W;
   localparam int WR_LEN  = ADDR_W + DATA_W;
   localparam int MAX_AR  = (ARB_LEN > RD_LEN) ? ARB_LEN : RD_LEN;
   localparam int BODY_W  = (MAX_AR > WR_LEN) ? MAX_AR : WR_LEN;
   localparam int CNT_W   = $clog2(BODY_W + TYPE_W + 1);

   generate
      if (SPD_W < 1)  begin : g_bad_spd  $error("SPD_W must be at least 1");  end
      if (PRIO_W < 2) begin : g_bad_prio $error("PRIO_W must be at least 2"); end
      if (ADDR_W < 1) begin : g_bad_addr $error("ADDR_W must be at least 1"); end
      if (DATA_W < 1) begin : g_bad_data $error("DATA_W must be at least 1"); end
   endgenerate

   lrq_state_e          state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [TYPE_W-1:0]   typ_q;
   logic [TYPE_W-1:0]   typ_nx;
   logic                map_legal;
   logic [CNT_W-1:0]    map_len_m1;
   logic [BODY_W-1:0]   body_q;
   logic                shift_clr;
   logic                shift_en;
   lrq_kind_e           cls_kind;
   logic [PRIO_W-1:0]   cls_prio;
   logic [ADDR_W-1:0]   cls_addr;
   logic [DATA_W-1:0]   cls_data;
   logic                cls_bad;

   assign typ_nx    = {typ_q[TYPE_W-2:0], req_line};
   assign shift_clr = (state_q == ST_IDLE) && req_line;
   assign shift_en  = (state_q == ST_BODY);

   lrq_type_map #(
      .CNT_W   (CNT_W),
      .ARB_LEN (ARB_LEN),
      .RD_LEN  (RD_LEN),
      .WR_LEN  (WR_LEN)
   ) i_map (
      .typ    (typ_nx),
      .legal  (map_legal),
      .len_m1 (map_len_m1)
   );

   lrq_shift_in #(.W(BODY_W)) i_body (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (shift_clr),
      .en    (shift_en),
      .din   (req_line),
      .q     (body_q)
   );

   lrq_classify #(
      .PRIO_W (PRIO_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BODY_W (BODY_W)
   ) i_cls (
      .typ      (typ_q),
      .body     (body_q),
      .kind     (cls_kind),
      .prio     (cls_prio),
      .addr     (cls_addr),
      .data     (cls_data),
      .bad_prio (cls_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         typ_q     <= '0;
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_kind  <= '0;
         out_prio  <= '0;
         out_addr  <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_line) begin
                  state_q <= ST_TYPE;
                  cnt_q   <= CNT_W'(TYPE_W - 1);
                  typ_q   <= '0;
               end
            end
            ST_TYPE: begin
               typ_q <= typ_nx;
               if (cnt_q == '0) begin
                  if (!map_legal) begin
                     out_err <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     cnt_q   <= map_len_m1;
                     state_q <= ST_BODY;
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_BODY: begin
               if (cnt_q == '0) state_q <= ST_STOP;
               else             cnt_q   <= cnt_q - CNT_W'(1);
            end
            ST_STOP: begin
               state_q <= ST_IDLE;
               if (req_line || cls_bad) begin
                  out_err <= 1'b1;
               end else begin
                  out_valid <= 1'b1;
                  out_kind  <= cls_kind;
                  out_prio  <= cls_prio;
                  out_addr  <= cls_addr;
                  out_data  <= cls_data;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lrq_frame_decoder_chk.sv
module lrq_frame_decoder_chk
   import lrq_pkg::*;
#(
   parameter int PRIO_W = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic              out_err,
   input logic [2:0]        out_kind,
   input logic [PRIO_W-1:0] out_prio,
   input logic [ADDR_W-1:0] out_addr,
   input logic [DATA_W-1:0] out_data
);
   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_err));

   p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid && !out_err);

   p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |=> !out_err && !out_valid);

   p_kind_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_kind <= 3'd4);

   p_fair_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 3'(K_FAIR)) |-> out_prio == '0);

   p_urgent_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 3'(K_URGENT)) |-> (out_prio != '0 && !(&out_prio)));

   p_regs_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_kind == 3'(K_READ) || out_kind == 3'(K_WRITE))) |-> out_prio == '0);

   p_arb_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind <= 3'(K_URGENT)) |-> (out_addr == '0 && out_data == '0));

   p_read_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 3'(K_READ)) |-> out_data == '0);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_kind) && $stable(out_prio) && $stable(out_addr) && $stable(out_data)));
endmodule

bind lrq_frame_decoder lrq_frame_decoder_chk #(
   .PRIO_W (PRIO_W),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_err   (out_err),
   .out_kind  (out_kind),
   .out_prio  (out_prio),
   .out_addr  (out_addr),
   .out_data  (out_data)
);

// File: tb/test_lrq_frame_decoder.sv
module test_lrq_frame_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_line = 1'b0;
   logic       out_valid;
   logic       out_err;
   logic [2:0] out_kind;
   logic [3:0] out_prio;
   logic [3:0] out_addr;
   logic [7:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   lrq_frame_decoder i_lrq_frame_decoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_line  (req_line),
      .out_valid (out_valid),
      .out_err   (out_err),
      .out_kind  (out_kind),
      .out_prio  (out_prio),
      .out_addr  (out_addr),
      .out_data  (out_data)
   );

   // entry: {req[46:43], len[42:38], frame[37:21] (first bit = bit len-1),
   //         valid[20], err[19], kind[18:16], prio[15:12], addr[11:8], data[7:0]}
   localparam int NV = 17;
   localparam logic [46:0] VEC [NV] = '{
      // R2 immediate, speed 10, priority 3
      {4'd2, 5'd11, {6'b0, 11'b1_000_10_0011_0}, 1'b1, 1'b0, 3'd0, 4'd3,  4'd0,  8'h00},
      // R4 same frame with other speed bits
      {4'd4, 5'd11, {6'b0, 11'b1_000_01_0011_0}, 1'b1, 1'b0, 3'd0, 4'd3,  4'd0,  8'h00},
      // R5 immediate with all-ones priority stays legal
      {4'd5, 5'd11, {6'b0, 11'b1_000_00_1111_0}, 1'b1, 1'b0, 3'd0, 4'd15, 4'd0,  8'h00},
      // R5 fair
      {4'd5, 5'd11, {6'b0, 11'b1_011_00_0000_0}, 1'b1, 1'b0, 3'd1, 4'd0,  4'd0,  8'h00},
      // R5 urgent, top legal value
      {4'd5, 5'd11, {6'b0, 11'b1_011_11_1110_0}, 1'b1, 1'b0, 3'd2, 4'd14, 4'd0,  8'h00},
      // R5 urgent, lowest value
      {4'd5, 5'd11, {6'b0, 11'b1_011_00_0001_0}, 1'b1, 1'b0, 3'd2, 4'd1,  4'd0,  8'h00},
      // R5 reserved priority
      {4'd5, 5'd11, {6'b0, 11'b1_011_00_1111_0}, 1'b0, 1'b1, 3'd0, 4'd0,  4'd0,  8'h00},
      // R3 read
      {4'd3, 5'd9,  {8'b0, 9'b1_100_1010_0},     1'b1, 1'b0, 3'd3, 4'd0,  4'd10, 8'h00},
      // R3 write
      {4'd3, 5'd17, 17'b1_101_0110_10100011_0,   1'b1, 1'b0, 3'd4, 4'd0,  4'd6,  8'hA3},
      // R6 bad stop on arbitration frame
      {4'd6, 5'd11, {6'b0, 11'b1_011_00_0010_1}, 1'b0, 1'b1, 3'd0, 4'd0,  4'd0,  8'h00},
      // R6 bad stop on read
      {4'd6, 5'd9,  {8'b0, 9'b1_100_0011_1},     1'b0, 1'b1, 3'd0, 4'd0,  4'd0,  8'h00},
      // R6 bad stop on write
      {4'd6, 5'd17, 17'b1_101_1111_00001111_1,   1'b0, 1'b1, 3'd0, 4'd0,  4'd0,  8'h00},
      // R2 reserved types 110, 111, 001, 010 (frame ends after type)
      {4'd2, 5'd4,  {13'b0, 4'b1_110},           1'b0, 1'b1, 3'd0, 4'd0,  4'd0,  8'h00},
      {4'd2, 5'd4,  {13'b0, 4'b1_111},           1'b0, 1'b1, 3'd0, 4'd0,  4'd0,  8'h00},
      {4'd2, 5'd4,  {13'b0, 4'b1_001},           1'b0, 1'b1, 3'd0, 4'd0,  4'd0,  8'h00},
      {4'd2, 5'd4,  {13'b0, 4'b1_010},           1'b0, 1'b1, 3'd0, 4'd0,  4'd0,  8'h00},
      // R9 write with all-ones address and data
      {4'd9, 5'd17, 17'b1_101_1111_11111111_0,   1'b1, 1'b0, 3'd4, 4'd0,  4'd15, 8'hFF}
   };

   task automatic chk(input string what, input int req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [16:0] fr, input int len, input int from);
      for (int i = from; i < len; i++) begin
         @(negedge clk);
         req_line = fr[len-1-i];
      end
   endtask

   task automatic expect_out(input int req, input bit ev, input bit ee,
                             input int k, input int p, input int a, input int d);
      chk("valid", req, int'(out_valid), int'(ev));
      chk("err",   req, int'(out_err),   int'(ee));
      if (ev) begin
         chk("kind", req, int'(out_kind), k);
         chk("prio", req, int'(out_prio), p);
         chk("addr", req, int'(out_addr), a);
         chk("data", req, int'(out_data), d);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R7 watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [16:0] fa;
      logic [16:0] fb;
      bit          seen;

      repeat (3) @(negedge clk);
      // R10 reset state
      expect_out(10, 1'b0, 1'b0, 0, 0, 0, 0);
      chk("kind at reset", 10, int'(out_kind), 0);
      chk("fields at reset", 10, int'({out_prio, out_addr, out_data}), 0);
      rst_n = 1'b1;

      // R1 idle line gives no pulses
      seen = 1'b0;
      repeat (20) begin
         @(negedge clk);
         if (out_valid || out_err) seen = 1'b1;
      end
      chk("pulse while idle", 1, int'(seen), 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         logic [46:0] e;
         e = VEC[v];
         send(e[37:21], int'(e[42:38]), 0);
         @(negedge clk);
         req_line = 1'b0;
         expect_out(int'(e[46:43]), e[20], e[19], int'(e[18:16]),
                    int'(e[15:12]), int'(e[11:8]), int'(e[7:0]));
         @(negedge clk);
         // R7 single-cycle pulse
         chk("valid after pulse", 7, int'(out_valid), 0);
         chk("err after pulse",   7, int'(out_err),   0);
         if (e[20]) begin
            // R9 fields held
            chk("held prio", 9, int'(out_prio), int'(e[15:12]));
            chk("held addr", 9, int'(out_addr), int'(e[11:8]));
            chk("held data", 9, int'(out_data), int'(e[7:0]));
         end
         @(negedge clk);
      end

      // R8 back-to-back frames
      fa = {8'b0, 9'b1_100_0101_0};
      fb = 17'b1_101_0011_01011100_0;
      send(fa, 9, 0);
      @(negedge clk);
      expect_out(8, 1'b1, 1'b0, 3, 0, 5, 0);
      req_line = fb[16];
      send(fb, 17, 1);
      @(negedge clk);
      req_line = 1'b0;
      expect_out(8, 1'b1, 1'b0, 4, 0, 3, 8'h5C);
      repeat (2) @(negedge clk);

      // R10 reset in the middle of a write frame
      fa = 17'b1_101_0110_10100011_0;
      send(fa, 8, 0);
      @(negedge clk);
      rst_n    = 1'b0;
      req_line = 1'b0;
      repeat (2) @(negedge clk);
      expect_out(10, 1'b0, 1'b0, 0, 0, 0, 0);
      chk("fields in reset", 10, int'({out_kind, out_prio, out_addr, out_data}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      fa = {8'b0, 9'b1_100_1001_0};
      send(fa, 9, 0);
      @(negedge clk);
      req_line = 1'b0;
      expect_out(10, 1'b1, 1'b0, 3, 0, 9, 0);
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule